// File: doc/BRIEF.md
# Synchronous Debug Link Host Serial Master

This block is the host end of a 17-bit synchronous serial debug link toward a target processor. A command port takes a 16-bit word together with a one-cycle start pulse. The engine builds a 17-bit frame from that word, with a cleared top bit, and generates the debug clock. It shifts the frame out most significant bit first on its serial data output. At the same time it assembles the 17-bit reply from the target's serial data line.

When the frame is complete, the engine raises a one-cycle done pulse. It then presents the captured reply together with a decoded status class, so the sequencing logic above it can decide what to do next. The rate of the debug clock comes from a half-period delay input, which is sampled once at the start of each frame.

The controller is a four-state machine:
- ST_IDLE: the clock is parked high.
- ST_LOW: the clock is low and the current bit is presented.
- ST_HIGH: the clock is high and the target shifts out its next bit.
- ST_FINISH: a single cycle that carries the done pulse.

Transitions:
- ST_IDLE or ST_FINISH to ST_LOW on a start pulse.
- ST_LOW to ST_HIGH when the half-period timer expires; the reply bit is captured on that edge.
- ST_HIGH to ST_LOW on expiry while bits remain; the transmit register advances on that edge.
- ST_HIGH to ST_FINISH on expiry after the seventeenth bit.
- ST_FINISH to ST_IDLE when no start is present.

Top module: `hsm_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, the debug clock output is high, busy is low, done is low and the reply output is zero until the first frame completes.
- R2: Each frame puts 17 bits on the serial data output, most significant first. The first bit is always 0 and the remaining 16 are the command word from bit 15 down to bit 0. Each bit is driven when the clock falls and stays stable across the following rising edge.
- R3: Every low phase and every high phase of the debug clock lasts half-period delay + 1 system clocks. Done is asserted in the cycle that follows the 34·(delay+1)-th rising system clock edge after the edge that accepted the start pulse.
- R4: The reply bit on the target's output line is sampled in the last system clock of each low phase. At done, the reply output holds the 17 sampled bits with the first one in bit 16. The reply output then holds until the next frame starts.
- R5: The class output decodes the reply as follows:
  - top bit 0 with value FFFF gives complete (1);
  - any other value with top bit 0 gives valid data (0);
  - top bit 1 with value 0000 gives not ready (2);
  - top bit 1 with value 0001 gives bus error (3);
  - top bit 1 with value FFFF gives illegal command (4);
  - any other value with top bit 1 gives protocol error (5).
- R6: Busy is high from the cycle after an accepted start until done. Done is a single-cycle pulse with busy low.
- R7: A start pulse while busy is ignored. A change of the delay input during a frame has no effect on that frame's timing or content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send a frame |
| cmd_i | input | 16 | Command word placed in the low 16 bits of the frame |
| half_dly_i | input | 8 | Half-period delay; each clock phase lasts this value + 1 cycles |
| tgt_sdo_i | input | 1 | Serial reply data from the target |
| dclk_o | output | 1 | Debug clock toward the target, idles high |
| host_sdo_o | output | 1 | Serial frame data toward the target |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when a frame has completed |
| reply_o | output | 17 | Captured 17-bit reply |
| class_o | output | 3 | Status class of the reply (encoding in R5) |

## Verification
The debug clock falls in the cycle after the accepting edge. Each phase then spans delay+1 cycles, so done is due exactly 34·(delay+1)+1 falling system clock edges after the start was driven. The bench counts falling edges from the start and compares that count with the formula, and it reads reply and class on the same falling edge that first shows done. A behavioural target model reacts only to the debug clock edges: it puts out its first reply bit when the clock first falls and later bits after each rising edge. This keeps the check of the sampling point independent of the delay value.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

    localparam int FRAME_W = 17;
    localparam int DATA_W  = FRAME_W - 1;

    typedef enum logic [2:0] {
        CLS_VALID    = 3'd0,
        CLS_COMPLETE = 3'd1,
        CLS_NOTREADY = 3'd2,
        CLS_BUSERR   = 3'd3,
        CLS_ILLEGAL  = 3'd4,
        CLS_PROTERR  = 3'd5
    } reply_class_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_FINISH = 2'd3
    } link_state_e;

endpackage

// File: rtl/hsm_ticker.sv
module hsm_ticker #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             reload_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             expired_o
);

    logic [DLY_W-1:0] period_q;
    logic [DLY_W-1:0] count_q;

    // Period is captured once per frame; later changes of dly_i are not seen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (arm_i) begin
            period_q <= dly_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (arm_i) begin
            count_q <= dly_i;
        end else if (reload_i) begin
            count_q <= period_q;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired_o = (count_q == '0);

endmodule

// File: rtl/hsm_shifter.sv
module hsm_shifter #(
    parameter int FRAME_W = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               advance_i,
    input  logic               capture_i,
    input  logic               rx_bit_i,
    output logic               tx_bit_o,
    output logic               last_o,
    output logic [FRAME_W-1:0] rx_word_o
);

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;
    logic [CNT_W-1:0]   left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            left_q <= '0;
        end else if (load_i) begin
            tx_q   <= frame_i;
            left_q <= FULL_CNT;
        end else if (advance_i) begin
            tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load_i) begin
            rx_q <= '0;
        end else if (capture_i) begin
            rx_q <= {rx_q[FRAME_W-2:0], rx_bit_i};
        end
    end

    assign tx_bit_o  = tx_q[FRAME_W-1];
    assign last_o    = (left_q == CNT_W'(1));
    assign rx_word_o = rx_q;

endmodule

// File: rtl/hsm_classify.sv
module hsm_classify
    import hsm_pkg::*;
#(
    parameter int FRAME_W = 17
) (
    input  logic [FRAME_W-1:0] word_i,
    output reply_class_e       class_o
);

    localparam int DW = FRAME_W - 1;
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
    localparam logic [DW-1:0] VAL_ZERO = '0;
    localparam logic [DW-1:0] VAL_ONE  = DW'(1);

    logic          flag;
    logic [DW-1:0] value;

    assign flag  = word_i[FRAME_W-1];
    assign value = word_i[DW-1:0];

    always_comb begin
        if (!flag) begin
            class_o = (value == ALL_ONES) ? CLS_COMPLETE : CLS_VALID;
        end else if (value == VAL_ZERO) begin
            class_o = CLS_NOTREADY;
        end else if (value == VAL_ONE) begin
            class_o = CLS_BUSERR;
        end else if (value == ALL_ONES) begin
            class_o = CLS_ILLEGAL;
        end else begin
            class_o = CLS_PROTERR;
        end
    end

endmodule

// File: rtl/hsm_top.sv
module hsm_top
    import hsm_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DATA_W-1:0]  cmd_i,
    input  logic [DLY_W-1:0]   half_dly_i,
    input  logic               tgt_sdo_i,
    output logic               dclk_o,
    output logic               host_sdo_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] reply_o,
    output logic [2:0]         class_o
);

    link_state_e  state_q, state_d;
    logic         arm, reload, advance, capture;
    logic         expired, last_bit;
    logic         dclk_q;
    reply_class_e cls;

    hsm_ticker #(.DLY_W(DLY_W)) u_ticker (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm),
        .reload_i  (reload),
        .dly_i     (half_dly_i),
        .expired_o (expired)
    );

    hsm_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (arm),
        .frame_i   ({1'b0, cmd_i}),
        .advance_i (advance),
        .capture_i (capture),
        .rx_bit_i  (tgt_sdo_i),
        .tx_bit_o  (host_sdo_o),
        .last_o    (last_bit),
        .rx_word_o (reply_o)
    );

    hsm_classify #(.FRAME_W(FRAME_W)) u_classify (
        .word_i  (reply_o),
        .class_o (cls)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_d = state_q;
        arm     = 1'b0;
        reload  = 1'b0;
        advance = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (start_i) begin
                    arm     = 1'b1;
                    state_d = ST_LOW;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_LOW: begin
                if (expired) begin
                    capture = 1'b1;
                    reload  = 1'b1;
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (expired) begin
                    if (last_bit) begin
                        state_d = ST_FINISH;
                    end else begin
                        advance = 1'b1;
                        reload  = 1'b1;
                        state_d = ST_LOW;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered debug clock: low exactly while in ST_LOW
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dclk_q <= 1'b1;
        end else begin
            dclk_q <= (state_d != ST_LOW);
        end
    end

    // Outputs
    always_comb begin
        dclk_o  = dclk_q;
        busy_o  = (state_q == ST_LOW) || (state_q == ST_HIGH);
        done_o  = (state_q == ST_FINISH);
        class_o = cls;
    end

endmodule

// File: rtl/hsm_chk.sv
module hsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       dclk_o,
    input logic       host_sdo_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [2:0] class_o
);

    p_idle_clock_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> dclk_o);

    p_first_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dclk_o) && $past(!busy_o)) |-> !host_sdo_o);

    p_data_hold_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $stable(host_sdo_o));

    p_class_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        class_o <= 3'd5);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_start_gives_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

endmodule

bind hsm_top hsm_chk u_hsm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dclk_o     (dclk_o),
    .host_sdo_o (host_sdo_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .class_o    (class_o)
);

// File: tb/hsm_top_tb_top.sv
`timescale 1ns/1ps
module hsm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] cmd_i = '0;
    logic [7:0]  half_dly_i = '0;
    logic        tgt_sdo_i = 1'b0;
    logic        dclk_o, host_sdo_o, busy_o, done_o;
    logic [16:0] reply_o;
    logic [2:0]  class_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Target model state
    logic [16:0] tgt_reply = '0;
    logic [16:0] tgt_rx = '0;
    int          tbit = 99;

    always #5 clk = ~clk;

    hsm_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmd_i      (cmd_i),
        .half_dly_i (half_dly_i),
        .tgt_sdo_i  (tgt_sdo_i),
        .dclk_o     (dclk_o),
        .host_sdo_o (host_sdo_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .reply_o    (reply_o),
        .class_o    (class_o)
    );

    // First reply bit appears once the clock first goes low
    always @(negedge dclk_o) begin
        if (tbit == 0) tgt_sdo_i <= tgt_reply[16];
    end

    // Target latches host data on rising edges, then moves to its next bit
    always @(posedge dclk_o) begin
        if (tbit >= 0 && tbit < 17) begin
            tgt_rx <= {tgt_rx[15:0], host_sdo_o};
            if (tbit + 1 < 17) tgt_sdo_i <= tgt_reply[15 - tbit];
            tbit <= tbit + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_class(input logic [16:0] w);
        if (!w[16]) return (w[15:0] == 16'hFFFF) ? 1 : 0;
        if (w[15:0] == 16'h0000) return 2;
        if (w[15:0] == 16'h0001) return 3;
        if (w[15:0] == 16'hFFFF) return 4;
        return 5;
    endfunction

    // Runs one frame; optionally pokes start and delay mid-frame
    task automatic run_frame(input logic [15:0] cmd, input logic [7:0] dly,
                             input logic [16:0] rep, input bit disturb);
        int n;
        int lim;
        bit busy_ok;
        tgt_reply = rep;
        tgt_rx    = '0;
        tbit      = 0;
        @(negedge clk);
        cmd_i      = cmd;
        half_dly_i = dly;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        busy_ok = busy_o;
        lim = 34 * (int'(dly) + 1) + 50;
        while (!done_o && n < lim) begin
            if (disturb && n == 5) begin
                start_i    = 1'b1;
                cmd_i      = ~cmd;
                half_dly_i = dly + 8'd3;
            end else if (disturb && n == 6) begin
                start_i = 1'b0;
            end
            if (!busy_o) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        check(done_o, "R6", "done seen", done_o, 1);
        check(busy_ok, "R6", "busy held during frame", busy_ok, 1);
        check(!busy_o, "R6", "busy low at done", busy_o, 0);
        check(n == 34 * (int'(dly) + 1) + 1, disturb ? "R7" : "R3",
              "cycles to done", n, 34 * (int'(dly) + 1) + 1);
        check(tgt_rx == {1'b0, cmd}, disturb ? "R7" : "R2",
              "frame seen by target", tgt_rx, {1'b0, cmd});
        check(reply_o == rep, "R4", "reply word", reply_o, rep);
        check(int'(class_o) == exp_class(rep), "R5", "class", class_o, exp_class(rep));
        @(negedge clk);
        check(!done_o, "R6", "done single pulse", done_o, 0);
        check(dclk_o, "R1", "clock idles high", dclk_o, 1);
        check(reply_o == rep, "R4", "reply held", reply_o, rep);
        half_dly_i = dly;
    endtask

    initial begin
        logic [16:0] reps [7];
        reps[0] = 17'h0_1234;
        reps[1] = 17'h0_FFFF;
        reps[2] = 17'h1_0000;
        reps[3] = 17'h1_0001;
        reps[4] = 17'h1_FFFF;
        reps[5] = 17'h1_5A5A;
        reps[6] = 17'h0_0000;

        repeat (3) @(negedge clk);
        check(dclk_o, "R1", "reset clock high", dclk_o, 1);
        check(!busy_o, "R1", "reset busy", busy_o, 0);
        check(!done_o, "R1", "reset done", done_o, 0);
        check(reply_o == '0, "R1", "reset reply", reply_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dclk_o && !busy_o, "R1", "idle after reset", {dclk_o, busy_o}, 2'b10);

        for (int d = 0; d < 4; d++) begin
            for (int r = 0; r < 7; r++) begin
                run_frame(16'hA5C3 ^ 16'(r * 16'h1111 + d * 16'h0F01), 8'(d), reps[r], 1'b0);
            end
        end
        // single-bit walk on command and reply at the fastest rate
        for (int b = 0; b < 16; b++) begin
            run_frame(16'(1) << b, 8'd0, 17'(1) << (16 - b), 1'b0);
        end
        // start and delay changes while busy (R7)
        run_frame(16'h2180, 8'd1, 17'h0_BEEF, 1'b1);
        run_frame(16'h1940, 8'd2, 17'h1_0001, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule